// File: doc/BRIEF.md
# Linear CCD line timing generator

This block derives every digital drive clock of a three-colour linear CCD sensor from one system clock. It produces two complementary shift-register phases, a reset-gate pulse, a clamp pulse, and one transfer-gate pulse shared by all three colour rows. The outputs go to external level shifters and drivers. It also tells downstream capture logic where it is in the line. It gives a line-start strobe, a running pixel index, and one flag for each pixel class: optical black, dummy or valid.

Each line has a fixed order. First comes a guard interval in which the shift phases are frozen. Then the transfer-gate pulse, then a second frozen guard, then the pixel readout. The readout shifts out a leading optical-black run, two leading dummies, the valid photocells and a short trailing dummy run. After the last pixel the generator idles until the programmed line period runs out. Two static inputs set the rate: the pixel period in system clocks and the line period in system clocks. Both are captured once at every line start. Guard lengths, pulse widths and segment sizes are parameters.

Top module: `ccd_line_timer`

## Requirements
- R1: While `rst` is high, every output is driven low and `pix_idx_o` is zero. The first output cycle after `rst` falls is a line start, with `line_start_o` high.
- R2: Take the cycle with `line_start_o` high as t=0. `tg_o` is high exactly for PRE_CYC <= t < PRE_CYC+TG_CYC in every line.
- R3: Outside reset, `phi2_o` is always the exact inverse of `phi1_o`. From t=0 up to READ_BEG = PRE_CYC+TG_CYC+POST_CYC, `phi1_o` is held high. It does not change within PRE_CYC cycles before the transfer pulse or POST_CYC cycles after it.
- R4: From t=READ_BEG on, a sub-count s = (t-READ_BEG) mod D runs, where D is the captured pixel period. `phi1_o` is high for s < floor(D/2) and low otherwise. This continues through the idle tail.
- R5: `rg_o` is high for s < RST_W in every pixel period, also during the guards and the transfer pulse. Before READ_BEG, s = t mod D.
- R6: `clamp_o` is high for RST_W+CLP_GAP <= s < RST_W+CLP_GAP+CLP_W. It is never high together with `rg_o`, and it is low in the cycle in which `rg_o` falls.
- R7: During readout, `pix_act_o` is high and `pix_idx_o` = floor((t-READ_BEG)/D), counting 0 to N-1, where N is the sum of the four segment sizes. Outside readout, `pix_act_o` is low and `pix_idx_o` is 0, including at every line start.
- R8: During readout, exactly one class flag is high, in this order of index: `pix_ob_o` for index < OB_N; `pix_dummy_o` for the next LEAD_N; `pix_valid_o` for the next VALID_N; `pix_dummy_o` for the last TRAIL_N. Outside readout all three flags are low.
- R9: A line lasts max(L, READ_BEG+N*D) cycles, where L is the captured line period. The next `line_start_o` falls exactly there.
- R10: `cfg_pix_div_i` and `cfg_line_len_i` are captured only in reset and at line start. A change in the middle of a line takes effect at the next line.
- R11: The pixel period equals D cycles and must be at least MIN_DIV. MIN_DIV is the larger of ceil(SYS_CLK_HZ/MAX_PIX_HZ) and RST_W+CLP_GAP+CLP_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pix_div_i | input | DIV_W | Pixel period in system clocks |
| cfg_line_len_i | input | LINE_W | Minimum line period in system clocks |
| phi1_o | output | 1 | Shift phase 1 |
| phi2_o | output | 1 | Shift phase 2, inverse of phase 1 |
| rg_o | output | 1 | Reset-gate pulse |
| clamp_o | output | 1 | Reset-level clamp pulse |
| tg_o | output | 1 | Transfer-gate pulse for all colour rows |
| line_start_o | output | 1 | One-cycle strobe on the first cycle of a line |
| pix_idx_o | output | IDX_W | Readout pixel index |
| pix_act_o | output | 1 | Readout in progress |
| pix_ob_o | output | 1 | Current pixel is optical black |
| pix_dummy_o | output | 1 | Current pixel is a leading or trailing dummy |
| pix_valid_o | output | 1 | Current pixel is a valid photocell |

## Verification
The assertions rely on two things from the driver of this block. `rst` must be held high from time zero. `cfg_pix_div_i` must never drop below MIN_DIV, because a shorter period would squeeze the reset and clamp pulses together and overrun the pixel-rate ceiling. The bench keeps to this: every divider it applies is at or above MIN_DIV, and it changes the configuration only while in reset or one cycle after a line start. That lets the capture-at-line-start rule be observed without breaking the rate constraint. It sweeps several pixel periods, odd and even, together with line periods that are shorter and longer than the readout. Every cycle of two whole lines per configuration is compared against an arithmetic model.

// File: rtl/ccd_timer_pkg.sv
package ccd_timer_pkg;

  // Coarse position within one line.
  typedef enum logic [1:0] {
    Z_PRE  = 2'd0,
    Z_TG   = 2'd1,
    Z_POST = 2'd2,
    Z_READ = 2'd3
  } line_zone_e;

  // Registered drive bundle toward the level shifters.
  typedef struct packed {
    logic phi1;
    logic phi2;
    logic rg;
    logic clamp;
    logic tg;
  } ccd_drive_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Exclusive end index of readout segment s (0: black, 1: lead, 2: valid, 3: trail).
  function automatic int seg_end(input int s, input int ob, input int lead,
                                 input int valid, input int trail);
    int e;
    e = ob;
    if (s >= 1) e += lead;
    if (s >= 2) e += valid;
    if (s >= 3) e += trail;
    return e;
  endfunction

endpackage

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_timer_pkg::*;
#(
  parameter int LINE_W   = 24,
  parameter int PRE_CYC  = 200,
  parameter int TG_CYC   = 2000,
  parameter int POST_CYC = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] line_len_i,
  input  logic              read_done_next_i,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic              wrap_o,
  output line_zone_e        zone_o,
  output logic              read_restart_o
);

  localparam int TG_BEG   = PRE_CYC;
  localparam int TG_END   = PRE_CYC + TG_CYC;
  localparam int READ_BEG = TG_END + POST_CYC;

  logic [LINE_W-1:0] cnt_q;
  logic [LINE_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (LINE_W+1)'(1);

  // Line ends once the period has elapsed and the readout has drained.
  assign wrap_o = (cnt_inc >= {1'b0, line_len_i}) && read_done_next_i;

  always_ff @(posedge clk) begin
    if (rst || wrap_o) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_inc[LINE_W-1:0];
    end
  end

  always_comb begin
    if (cnt_q < LINE_W'(TG_BEG)) begin
      zone_o = Z_PRE;
    end else if (cnt_q < LINE_W'(TG_END)) begin
      zone_o = Z_TG;
    end else if (cnt_q < LINE_W'(READ_BEG)) begin
      zone_o = Z_POST;
    end else begin
      zone_o = Z_READ;
    end
  end

  // Pixel sub-count realigns so that readout starts on a pixel boundary.
  assign read_restart_o = (cnt_q == LINE_W'(READ_BEG - 1));
  assign line_cnt_o     = cnt_q;

endmodule

// File: rtl/ccd_pix_clock.sv
module ccd_pix_clock #(
  parameter int DIV_W   = 10,
  parameter int RST_W   = 10,
  parameter int CLP_GAP = 3,
  parameter int CLP_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  input  logic             hold_i,
  output logic             tick_o,
  output logic             phi1_o,
  output logic             rg_o,
  output logic             clamp_o
);

  localparam int CLP_BEG = RST_W + CLP_GAP;
  localparam int CLP_END = CLP_BEG + CLP_W;

  logic [DIV_W-1:0] sub_q;

  assign tick_o = (sub_q >= (div_i - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      sub_q <= '0;
    end else if (tick_o) begin
      sub_q <= '0;
    end else begin
      sub_q <= sub_q + DIV_W'(1);
    end
  end

  // Phase 1 is frozen high around the transfer pulse, else a half-period square wave.
  assign phi1_o  = hold_i | (sub_q < (div_i >> 1));
  assign rg_o    = (sub_q < DIV_W'(RST_W));
  assign clamp_o = (sub_q >= DIV_W'(CLP_BEG)) && (sub_q < DIV_W'(CLP_END));

endmodule

// File: rtl/ccd_pix_index.sv
module ccd_pix_index
  import ccd_timer_pkg::*;
#(
  parameter int  OB_N    = 49,
  parameter int  LEAD_N  = 2,
  parameter int  VALID_N = 10600,
  parameter int  TRAIL_N = 3,
  localparam int NPIX    = OB_N + LEAD_N + VALID_N + TRAIL_N,
  localparam int IDX_W   = $clog2(NPIX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             in_read_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             act_o,
  output logic             ob_o,
  output logic             dummy_o,
  output logic             valid_o,
  output logic             done_next_o
);

  logic [IDX_W-1:0] cnt_q;
  logic [3:0]       below;

  // below[s]: current index lies before the end of segment s.
  for (genvar s = 0; s < 4; s++) begin : g_seg
    localparam int EDGE = seg_end(s, OB_N, LEAD_N, VALID_N, TRAIL_N);
    assign below[s] = (cnt_q < IDX_W'(EDGE));
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (step_i && below[3]) begin
      cnt_q <= cnt_q + IDX_W'(1);
    end
  end

  assign act_o   = in_read_i && below[3];
  assign ob_o    = act_o && below[0];
  assign dummy_o = act_o && ((below[1] && !below[0]) || !below[2]);
  assign valid_o = act_o && below[2] && !below[1];
  assign idx_o   = act_o ? cnt_q : '0;

  assign done_next_o = (cnt_q == IDX_W'(NPIX)) ||
                       (step_i && (cnt_q == IDX_W'(NPIX - 1)));

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timer_pkg::*;
#(
  parameter int  SYS_CLK_HZ = 200_000_000,
  parameter int  MAX_PIX_HZ = 5_000_000,
  parameter int  OB_N       = 49,
  parameter int  LEAD_N     = 2,
  parameter int  VALID_N    = 10600,
  parameter int  TRAIL_N    = 3,
  parameter int  PRE_CYC    = 200,
  parameter int  TG_CYC     = 2000,
  parameter int  POST_CYC   = 200,
  parameter int  RST_W      = 10,
  parameter int  CLP_GAP    = 3,
  parameter int  CLP_W      = 10,
  parameter int  DIV_W      = 10,
  parameter int  LINE_W     = 24,
  localparam int IDX_W      = $clog2(OB_N + LEAD_N + VALID_N + TRAIL_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_pix_div_i,
  input  logic [LINE_W-1:0] cfg_line_len_i,
  output logic              phi1_o,
  output logic              phi2_o,
  output logic              rg_o,
  output logic              clamp_o,
  output logic              tg_o,
  output logic              line_start_o,
  output logic [IDX_W-1:0]  pix_idx_o,
  output logic              pix_act_o,
  output logic              pix_ob_o,
  output logic              pix_dummy_o,
  output logic              pix_valid_o
);

  localparam int RATE_DIV  = ceil_div(SYS_CLK_HZ, MAX_PIX_HZ);
  localparam int PULSE_DIV = RST_W + CLP_GAP + CLP_W;
  localparam int MIN_DIV   = max3(RATE_DIV, PULSE_DIV, 2);

  // Captured configuration, refreshed only in reset and at line start.
  logic [DIV_W-1:0]  div_q;
  logic [LINE_W-1:0] len_q;

  logic [LINE_W-1:0] line_cnt;
  logic              wrap;
  line_zone_e        zone;
  logic              read_restart;
  logic              in_read;
  logic              tick;
  logic              phi1_n;
  logic              rg_n;
  logic              clamp_n;
  logic [IDX_W-1:0]  idx_n;
  logic              act_n;
  logic              ob_n;
  logic              dummy_n;
  logic              valid_n;
  logic              done_next;
  ccd_drive_t        drv_q;

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      div_q <= cfg_pix_div_i;
      len_q <= cfg_line_len_i;
    end
  end

  assign in_read = (zone == Z_READ);

  ccd_line_seq #(
    .LINE_W   (LINE_W),
    .PRE_CYC  (PRE_CYC),
    .TG_CYC   (TG_CYC),
    .POST_CYC (POST_CYC)
  ) u_seq (
    .clk              (clk),
    .rst              (rst),
    .line_len_i       (len_q),
    .read_done_next_i (done_next),
    .line_cnt_o       (line_cnt),
    .wrap_o           (wrap),
    .zone_o           (zone),
    .read_restart_o   (read_restart)
  );

  ccd_pix_clock #(
    .DIV_W   (DIV_W),
    .RST_W   (RST_W),
    .CLP_GAP (CLP_GAP),
    .CLP_W   (CLP_W)
  ) u_pclk (
    .clk       (clk),
    .rst       (rst),
    .div_i     (div_q),
    .restart_i (wrap | read_restart),
    .hold_i    (!in_read),
    .tick_o    (tick),
    .phi1_o    (phi1_n),
    .rg_o      (rg_n),
    .clamp_o   (clamp_n)
  );

  ccd_pix_index #(
    .OB_N    (OB_N),
    .LEAD_N  (LEAD_N),
    .VALID_N (VALID_N),
    .TRAIL_N (TRAIL_N)
  ) u_pidx (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (wrap),
    .step_i      (tick && in_read),
    .in_read_i   (in_read),
    .idx_o       (idx_n),
    .act_o       (act_n),
    .ob_o        (ob_n),
    .dummy_o     (dummy_n),
    .valid_o     (valid_n),
    .done_next_o (done_next)
  );

  // Output register stage: every pin toggles from a flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q        <= '0;
      line_start_o <= 1'b0;
      pix_idx_o    <= '0;
      pix_act_o    <= 1'b0;
      pix_ob_o     <= 1'b0;
      pix_dummy_o  <= 1'b0;
      pix_valid_o  <= 1'b0;
    end else begin
      drv_q.phi1   <= phi1_n;
      drv_q.phi2   <= !phi1_n;
      drv_q.rg     <= rg_n;
      drv_q.clamp  <= clamp_n;
      drv_q.tg     <= (zone == Z_TG);
      line_start_o <= (line_cnt == '0);
      pix_idx_o    <= idx_n;
      pix_act_o    <= act_n;
      pix_ob_o     <= ob_n;
      pix_dummy_o  <= dummy_n;
      pix_valid_o  <= valid_n;
    end
  end

  assign phi1_o  = drv_q.phi1;
  assign phi2_o  = drv_q.phi2;
  assign rg_o    = drv_q.rg;
  assign clamp_o = drv_q.clamp;
  assign tg_o    = drv_q.tg;

endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
  parameter int PRE_CYC  = 200,
  parameter int POST_CYC = 200,
  parameter int MIN_DIV  = 40,
  parameter int DIV_W    = 10,
  parameter int IDX_W    = 14
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] cfg_pix_div_i,
  input logic             phi1_o,
  input logic             phi2_o,
  input logic             rg_o,
  input logic             clamp_o,
  input logic             tg_o,
  input logic             line_start_o,
  input logic [IDX_W-1:0] pix_idx_o,
  input logic             pix_act_o,
  input logic             pix_ob_o,
  input logic             pix_dummy_o,
  input logic             pix_valid_o
);

  logic        live;
  logic        phi1_q;
  logic [31:0] streak;
  logic [31:0] since_tg;

  // Window counters for the guard intervals, kept here instead of deep $past.
  always_ff @(posedge clk) begin
    if (rst) begin
      live     <= 1'b0;
      phi1_q   <= 1'b0;
      streak   <= '0;
      since_tg <= '1;
    end else begin
      live     <= 1'b1;
      phi1_q   <= phi1_o;
      streak   <= (phi1_o == phi1_q) ? ((streak == '1) ? streak : streak + 32'd1) : 32'd1;
      since_tg <= tg_o ? 32'd0 : ((since_tg == '1) ? since_tg : since_tg + 32'd1);
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !(phi1_o || phi2_o || rg_o || clamp_o || tg_o || line_start_o ||
              pix_act_o || pix_ob_o || pix_dummy_o || pix_valid_o) && (pix_idx_o == '0));

  p_first_line_r1: assert property (@(posedge clk)
    $fell(rst) |=> line_start_o);

  p_phase_compl_r3: assert property (@(posedge clk) disable iff (rst)
    live |-> (phi1_o != phi2_o));

  p_tg_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    tg_o |-> (phi1_o && !phi2_o));

  p_tg_pre_guard_r2: assert property (@(posedge clk) disable iff (rst)
    (live && $rose(tg_o)) |-> (streak >= 32'(PRE_CYC)));

  p_tg_post_guard_r3: assert property (@(posedge clk) disable iff (rst)
    (live && (phi1_o != phi1_q)) |-> (since_tg >= 32'(POST_CYC)));

  p_rg_clamp_apart_r6: assert property (@(posedge clk) disable iff (rst)
    !(rg_o && clamp_o));

  p_clamp_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (live && $fell(rg_o)) |-> !clamp_o);

  p_class_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    pix_act_o |-> ($countones({pix_ob_o, pix_dummy_o, pix_valid_o}) == 1));

  p_class_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !pix_act_o |-> !(pix_ob_o || pix_dummy_o || pix_valid_o));

  p_idx_step_r7: assert property (@(posedge clk) disable iff (rst)
    (live && pix_act_o && $past(pix_act_o)) |->
      ((pix_idx_o == $past(pix_idx_o)) || (pix_idx_o == $past(pix_idx_o) + IDX_W'(1))));

  p_line_start_idx_r7: assert property (@(posedge clk) disable iff (rst)
    line_start_o |-> (!pix_act_o && (pix_idx_o == '0)));

  p_div_rate_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_pix_div_i >= DIV_W'(MIN_DIV));

endmodule

bind ccd_line_timer ccd_line_timer_chk #(
  .PRE_CYC  (PRE_CYC),
  .POST_CYC (POST_CYC),
  .MIN_DIV  (MIN_DIV),
  .DIV_W    (DIV_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_pix_div_i (cfg_pix_div_i),
  .phi1_o        (phi1_o),
  .phi2_o        (phi2_o),
  .rg_o          (rg_o),
  .clamp_o       (clamp_o),
  .tg_o          (tg_o),
  .line_start_o  (line_start_o),
  .pix_idx_o     (pix_idx_o),
  .pix_act_o     (pix_act_o),
  .pix_ob_o      (pix_ob_o),
  .pix_dummy_o   (pix_dummy_o),
  .pix_valid_o   (pix_valid_o)
);

// File: tb/ccd_line_timer_tb.sv
`timescale 1ns/1ps
module ccd_line_timer_tb;

  localparam int OB      = 3;
  localparam int LEAD    = 2;
  localparam int VALID   = 6;
  localparam int TRAIL   = 2;
  localparam int NPIX    = OB + LEAD + VALID + TRAIL;
  localparam int PRE     = 3;
  localparam int TG      = 5;
  localparam int POST    = 2;
  localparam int RB      = PRE + TG + POST;
  localparam int RW      = 2;
  localparam int GAP     = 1;
  localparam int CW      = 2;
  localparam int MIN_DIV = 5;
  localparam int DW      = 5;
  localparam int LW      = 12;
  localparam int IW      = $clog2(NPIX + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] cfg_div = DW'(MIN_DIV);
  logic [LW-1:0] cfg_len = '0;
  logic          phi1, phi2, rg, clamp, tg, ls, act, ob, dm, vl;
  logic [IW-1:0] idx;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ccd_line_timer #(
    .SYS_CLK_HZ (200_000_000),
    .MAX_PIX_HZ (40_000_000),
    .OB_N       (OB),
    .LEAD_N     (LEAD),
    .VALID_N    (VALID),
    .TRAIL_N    (TRAIL),
    .PRE_CYC    (PRE),
    .TG_CYC     (TG),
    .POST_CYC   (POST),
    .RST_W      (RW),
    .CLP_GAP    (GAP),
    .CLP_W      (CW),
    .DIV_W      (DW),
    .LINE_W     (LW)
  ) u_dut (
    .clk            (clk),
    .rst            (rst),
    .cfg_pix_div_i  (cfg_div),
    .cfg_line_len_i (cfg_len),
    .phi1_o         (phi1),
    .phi2_o         (phi2),
    .rg_o           (rg),
    .clamp_o        (clamp),
    .tg_o           (tg),
    .line_start_o   (ls),
    .pix_idx_o      (idx),
    .pix_act_o      (act),
    .pix_ob_o       (ob),
    .pix_dummy_o    (dm),
    .pix_valid_o    (vl)
  );

  task automatic chk(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, actual, expected, $time);
    end
  endtask

  task automatic chk_quiet();
    chk("R1", "reset phi1", int'(phi1), 0);
    chk("R1", "reset phi2", int'(phi2), 0);
    chk("R1", "reset rg", int'(rg), 0);
    chk("R1", "reset clamp", int'(clamp), 0);
    chk("R1", "reset tg", int'(tg), 0);
    chk("R1", "reset line start", int'(ls), 0);
    chk("R1", "reset flags", int'({act, ob, dm, vl}), 0);
    chk("R1", "reset index", int'(idx), 0);
  endtask

  // Checks one whole line cycle by cycle; the current sample must be t=0.
  // Applies the next configuration at t=1 (R10: must not affect this line).
  task automatic run_line(input int div, input int len, input int ndiv, input int nlen,
                          input bit first);
    int read_end, lend, last_rise;
    bit prev_rg;
    read_end  = RB + NPIX * div;
    lend      = (len > read_end) ? len : read_end;
    last_rise = -1;
    prev_rg   = 1'b0;
    for (int t = 0; t < lend; t++) begin
      bit hold, e_phi1, e_act;
      int sub, pidx;
      hold   = (t < RB);
      sub    = hold ? (t % div) : ((t - RB) % div);
      e_phi1 = hold ? 1'b1 : (sub < div / 2);
      pidx   = hold ? 0 : (t - RB) / div;
      e_act  = !hold && (pidx < NPIX);
      if (t == 0) chk(first ? "R1" : "R9", "line start at t=0", int'(ls), 1);
      else        chk("R9", "no line start mid-line", int'(ls), 0);
      chk("R2", "transfer gate", int'(tg), int'(t >= PRE && t < PRE + TG));
      chk(hold ? "R3" : "R4", "phase 1", int'(phi1), int'(e_phi1));
      chk("R3", "phase 2 inverse", int'(phi2), int'(!e_phi1));
      chk("R5", "reset gate", int'(rg), int'(sub < RW));
      chk("R6", "clamp", int'(clamp), int'(sub >= RW + GAP && sub < RW + GAP + CW));
      chk("R7", "active", int'(act), int'(e_act));
      chk("R7", "index", int'(idx), e_act ? pidx : 0);
      chk("R8", "black flag", int'(ob), int'(e_act && pidx < OB));
      chk("R8", "dummy flag", int'(dm), int'(e_act && ((pidx >= OB && pidx < OB + LEAD) ||
                                                       pidx >= OB + LEAD + VALID)));
      chk("R8", "valid flag", int'(vl), int'(e_act && pidx >= OB + LEAD &&
                                                pidx < OB + LEAD + VALID));
      if (rg && !prev_rg && t >= RB) begin
        if (last_rise >= RB) begin
          chk("R11", "pixel period", t - last_rise, div);
          chk("R11", "period not below minimum", int'((t - last_rise) >= MIN_DIV), 1);
        end
        last_rise = t;
      end
      prev_rg = rg;
      if (t == 1) begin
        cfg_div = DW'(ndiv);
        cfg_len = LW'(nlen);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cdiv[5];
    int clen[5];
    cdiv = '{5, 6, 7, 9, 5};
    clen = '{0, 97, 50, 140, 120};
    repeat (4) @(negedge clk);
    chk_quiet();
    for (int i = 0; i < 5; i++) begin
      int j;
      j = (i + 1) % 5;
      rst     = 1'b1;
      cfg_div = DW'(cdiv[i]);
      cfg_len = LW'(clen[i]);
      repeat (3) @(negedge clk);
      chk_quiet();
      rst = 1'b0;
      @(negedge clk);
      run_line(cdiv[i], clen[i], cdiv[j], clen[j], 1'b1);
      run_line(cdiv[j], clen[j], cdiv[j], clen[j], 1'b0);
      // Reset arrives in the middle of a line.
      repeat (RB + 3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk_quiet();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule